// File: doc/BRIEF.md
# Configuration and Result I2C Target

This block is the two-wire serial target that sits in front of a data converter. A fast system clock samples the serial clock and data lines. The block picks out start, repeated-start and stop conditions and answers one fixed 7-bit device address. A write transaction loads a configuration word that the converter front end consumes: channel selection, rejection mode, speed mode and gain bits, packed as the integration decides. A read transaction returns the most recent conversion word, which the converter presents on a parallel input.

The data line is open-drain. The block never drives it high. It only asserts a pull-low enable, and a released line reads high through an external pull-up. A controller may write the configuration, issue a repeated start and read the result inside one transaction without ever freeing the bus.

Top module: `cfgi2c_target`

## Requirements
- R1: After reset the pull-low enable is 0, the bus-busy flag is 0 and the configuration word equals the CFG_RST parameter.
- R2: An SDA fall while SCL is high (start) sets the bus-busy flag. An SDA rise while SCL is high (stop) clears it and releases SDA.
- R3: The first byte after a start is seven address bits, MSB first, followed by a direction bit (1 = read, 0 = write). On an address match the block pulls SDA low through the ninth clock. On any other address it never pulls SDA before the next start, and later bytes leave the configuration unchanged.
- R4: In a write, data byte k (k = 0, 1, ...) is sampled MSB first on SCL rising edges and stored at cfg_o[8*(CFG_BYTES-k)-1 -: 8], so the first byte lands in the most significant byte. Bytes not sent keep their old value, and each stored byte is acknowledged.
- R5: In a write, every data byte beyond the CFG_BYTES-th is not acknowledged (SDA stays released on its ninth clock) and changes no configuration bit.
- R6: In a read, result_i is captured when the address acknowledge clock falls. It is shifted out MSB first, with each bit set up after an SCL fall. Later changes on result_i do not affect that transaction.
- R7: After all RES_BYTES result bytes have been sent, further read bytes return 8'hFF (SDA released).
- R8: When the controller leaves SDA high on the ninth clock of a read byte, the block releases SDA and does not pull it again until the next start.
- R9: A repeated start after a write begins a fresh address phase. The bus-busy flag stays 1 throughout, and a read in the same transaction returns the result.
- R10: The pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| result_i | input | 8*RES_BYTES | Latest conversion word |
| cfg_o | output | 8*CFG_BYTES | Configuration word for the converter front end |
| busy_o | output | 1 | Bus held between a start and a stop |

## Verification
The assertions assume that each SCL high and low phase lasts longer than the synchronizer latency of SYNC_STAGES plus one system cycles. They also assume the controller moves SDA only well inside the SCL low phase, except when it forms a start or a stop, and never issues a stop while the block holds SDA low. The bench controller keeps every SCL phase at least 16 system cycles long. It changes SDA eight cycles after an SCL fall and models the wired line as the AND of its own drive and the block's release.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_HOLD
   } link_state_t;

endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[g] <= RST_VAL;
               else        chain_q[g] <= line_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[g] <= RST_VAL;
               else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   assign line_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgi2c_cond_detect.sv
module cfgi2c_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end

   assign scl_rise_o = scl_s & ~scl_d;
   assign scl_fall_o = ~scl_s & scl_d;
   // data edges with the clock held high are bus conditions, not data
   assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfgi2c_cfg_store.sv
module cfgi2c_cfg_store #(
   parameter int BYTES = 2,
   parameter int IDX_W = 1,
   parameter logic [8*BYTES-1:0] RST = '0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [7:0]         din_i,
   output logic [8*BYTES-1:0] cfg_o
);
   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_slot
         // byte index 0 occupies the most significant slot
         localparam logic [IDX_W-1:0] SLOT = IDX_W'(BYTES - 1 - g);
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                        cfg_o[8*g +: 8] <= RST[8*g +: 8];
            else if (we_i && (idx_i == SLOT))  cfg_o[8*g +: 8] <= din_i;
      end
   endgenerate
endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         CFG_BYTES   = 2,
   parameter int         RES_BYTES   = 3,
   parameter int         SYNC_STAGES = 2,
   parameter logic [8*CFG_BYTES-1:0] CFG_RST = '0
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_pull_o,
   input  logic [8*RES_BYTES-1:0] result_i,
   output logic [8*CFG_BYTES-1:0] cfg_o,
   output logic                   busy_o
);
   localparam int CFG_W = 8 * CFG_BYTES;
   localparam int RES_W = 8 * RES_BYTES;
   localparam int IDX_W = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1;
   localparam int CNT_W = $clog2(CFG_BYTES + 1);
   localparam logic [CNT_W-1:0] CFG_LAST = CNT_W'(CFG_BYTES);
   localparam logic [CNT_W-1:0] IDX_ONE  = CNT_W'(1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be 2 or more");
      end
      if (CFG_BYTES < 1 || CFG_BYTES > 16) begin : g_bad_cfg
         $error("CFG_BYTES must be within 1..16");
      end
      if (RES_BYTES < 1 || RES_BYTES > 16) begin : g_bad_res
         $error("RES_BYTES must be within 1..16");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   cfgi2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_s));
   cfgi2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_s));

   cfgi2c_cond_detect u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det));

   link_state_t      state;
   logic [3:0]       bit_cnt;
   logic [7:0]       rx_sh;
   logic [RES_W-1:0] tx_sh;
   logic             tx_active;
   logic             ack_pull;
   logic             rw_q;
   logic             master_ack;
   logic             busy_q;
   logic [CNT_W-1:0] wr_idx;
   logic             byte_end;
   logic             cfg_we;

   assign byte_end = scl_fall && (bit_cnt == 4'd8);
   assign cfg_we   = (state == ST_WR_DATA) && byte_end && (wr_idx < CFG_LAST)
                     && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= 4'd0;
         rx_sh      <= 8'd0;
         tx_sh      <= '1;
         tx_active  <= 1'b0;
         ack_pull   <= 1'b0;
         rw_q       <= 1'b0;
         master_ack <= 1'b0;
         busy_q     <= 1'b0;
         wr_idx     <= '0;
      end else if (start_det) begin
         state     <= ST_ADDR;
         busy_q    <= 1'b1;
         bit_cnt   <= 4'd0;
         tx_active <= 1'b0;
         ack_pull  <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         busy_q    <= 1'b0;
         tx_active <= 1'b0;
         ack_pull  <= 1'b0;
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_end) begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                     rw_q     <= rx_sh[0];
                     ack_pull <= 1'b1;
                     state    <= ST_ADDR_ACK;
                  end else begin
                     state    <= ST_HOLD;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  ack_pull <= 1'b0;
                  bit_cnt  <= 4'd0;
                  if (rw_q) begin
                     tx_sh     <= result_i;
                     tx_active <= 1'b1;
                     state     <= ST_RD_DATA;
                  end else begin
                     wr_idx    <= '0;
                     state     <= ST_WR_DATA;
                  end
               end
            end
            ST_WR_DATA: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_end) begin
                  if (wr_idx < CFG_LAST) begin
                     ack_pull <= 1'b1;
                     state    <= ST_WR_ACK;
                  end else begin
                     state    <= ST_HOLD;
                  end
               end
            end
            ST_WR_ACK: begin
               if (scl_fall) begin
                  ack_pull <= 1'b0;
                  bit_cnt  <= 4'd0;
                  wr_idx   <= wr_idx + IDX_ONE;
                  state    <= ST_WR_DATA;
               end
            end
            ST_RD_DATA: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_end) begin
                  tx_active <= 1'b0;
                  state     <= ST_RD_ACK;
               end else if (scl_fall && bit_cnt != 4'd0) begin
                  tx_sh <= {tx_sh[RES_W-2:0], 1'b1};
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  master_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (master_ack) begin
                     tx_sh     <= {tx_sh[RES_W-2:0], 1'b1};
                     tx_active <= 1'b1;
                     bit_cnt   <= 4'd0;
                     state     <= ST_RD_DATA;
                  end else begin
                     state     <= ST_HOLD;
                  end
               end
            end
            ST_IDLE, ST_HOLD: begin
               tx_active <= 1'b0;
               ack_pull  <= 1'b0;
            end
            default: state <= ST_IDLE;
         endcase
      end

   cfgi2c_cfg_store #(.BYTES(CFG_BYTES), .IDX_W(IDX_W), .RST(CFG_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we),
      .idx_i(wr_idx[IDX_W-1:0]), .din_i(rx_sh), .cfg_o(cfg_o));

   assign sda_pull_o = ack_pull | (tx_active & ~tx_sh[RES_W-1]);
   assign busy_o     = busy_q;
endmodule

// File: rtl/cfgi2c_target_chk.sv
module cfgi2c_target_chk #(
   parameter int CFG_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_pull_o,
   input logic             busy_o,
   input logic             start_det,
   input logic             stop_det,
   input logic [CFG_W-1:0] cfg_o
);
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !sda_pull_o);                                  // R2
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> busy_o);                                     // R2
   AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!busy_o && !sda_pull_o));                    // R2
   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_i);                          // R10
   AST_CFG_IN_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_o) |-> (busy_o && !scl_i));                   // R4
endmodule

bind cfgi2c_target cfgi2c_target_chk #(.CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
   .busy_o(busy_o), .start_det(start_det), .stop_det(stop_det), .cfg_o(cfg_o));

// File: tb/tb_cfgi2c_target.sv
module tb_cfgi2c_target;
   localparam logic [6:0] DEV = 7'h2A;
   localparam int Q = 8;
   localparam int H = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        pull;
   logic        busy;
   logic [23:0] res = 24'h0;
   logic [15:0] cfg;
   logic        sda_line;

   int n_chk = 0, n_err = 0;
   int pull_cnt = 0, busy_low = 0, r10_viol = 0;
   logic pull_d = 1'b0;
   bit done = 0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~pull;

   cfgi2c_target #(.DEV_ADDR(DEV), .CFG_BYTES(2), .RES_BYTES(3)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_pull_o(pull), .result_i(res), .cfg_o(cfg), .busy_o(busy));

   always @(negedge clk) begin
      if (pull) pull_cnt++;
      if (!busy) busy_low++;
      if (rst_n && (pull !== pull_d) && scl) r10_viol++;
      pull_d = pull;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(Q);
      scl = 1'b1;   wt(Q);
      sda_m = 1'b0; wt(Q);
      scl = 1'b0;   wt(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(Q);
      scl = 1'b1;   wt(Q);
      sda_m = 1'b1; wt(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wt(Q);
      scl = 1'b1; wt(H);
      scl = 1'b0; wt(Q);
   endtask

   task automatic write_byte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      sda_m = 1'b1; wt(Q);
      scl = 1'b1; wt(H/2);
      ack = ~sda_line; wt(H/2);
      scl = 1'b0; wt(Q);
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wt(Q);
         scl = 1'b1; wt(H/2);
         d[i] = sda_line; wt(H/2);
         scl = 1'b0; wt(Q);
      end
      send_bit(~give_ack);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic        ack;
      logic [7:0]  d;
      logic [15:0] cfg_exp;
      logic [23:0] rv;

      wt(5);
      chk("R1 pull", {31'd0, pull}, 32'd0);
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 cfg",  {16'd0, cfg}, 32'd0);
      rst_n = 1'b1;
      wt(5);
      cfg_exp = 16'h0000;

      // R2: start and stop
      bus_start();
      chk("R2 busy after start", {31'd0, busy}, 32'd1);
      bus_stop();
      wt(Q);
      chk("R2 busy after stop", {31'd0, busy}, 32'd0);

      // R3: full address sweep, write direction
      for (int a = 0; a < 128; a++) begin
         bus_start();
         pull_cnt = 0;
         write_byte({7'(a), 1'b0}, ack);
         if (7'(a) == DEV) chk("R3 match ack", {31'd0, ack}, 32'd1);
         else begin
            chk("R3 mismatch ack", {31'd0, ack}, 32'd0);
            chk("R3 mismatch pull", pull_cnt, 0);
         end
         bus_stop();
      end

      // R3: data after a foreign address is ignored
      bus_start();
      pull_cnt = 0;
      write_byte({DEV ^ 7'h01, 1'b0}, ack);
      write_byte(8'hEE, ack);
      chk("R3 foreign data ack", {31'd0, ack}, 32'd0);
      chk("R3 foreign pull", pull_cnt, 0);
      bus_stop();
      chk("R3 cfg unchanged", {16'd0, cfg}, {16'd0, cfg_exp});

      // R4/R5: full writes with an overflow byte
      for (int k = 0; k < 4; k++) begin
         logic [7:0] b0, b1;
         b0 = 8'(k * 37 + 5);
         b1 = ~b0 ^ 8'(k);
         bus_start();
         write_byte({DEV, 1'b0}, ack);
         chk("R3 addr ack", {31'd0, ack}, 32'd1);
         write_byte(b0, ack);
         chk("R4 byte0 ack", {31'd0, ack}, 32'd1);
         write_byte(b1, ack);
         chk("R4 byte1 ack", {31'd0, ack}, 32'd1);
         write_byte(8'h99, ack);
         chk("R5 overflow nak", {31'd0, ack}, 32'd0);
         bus_stop();
         cfg_exp = {b0, b1};
         chk("R4 R5 cfg", {16'd0, cfg}, {16'd0, cfg_exp});
      end

      // R4: single byte write keeps the low byte
      bus_start();
      write_byte({DEV, 1'b0}, ack);
      write_byte(8'hC3, ack);
      bus_stop();
      cfg_exp = {8'hC3, cfg_exp[7:0]};
      chk("R4 partial cfg", {16'd0, cfg}, {16'd0, cfg_exp});

      // R6/R7: reads over several result words
      for (int k = 0; k < 6; k++) begin
         rv = (24'(k) * 24'h1F3A57) ^ 24'hA5C300;
         res = rv;
         bus_start();
         write_byte({DEV, 1'b1}, ack);
         chk("R6 read addr ack", {31'd0, ack}, 32'd1);
         res = ~rv;
         read_byte(1'b1, d);
         chk("R6 byte0", {24'd0, d}, {24'd0, rv[23:16]});
         read_byte(1'b1, d);
         chk("R6 byte1", {24'd0, d}, {24'd0, rv[15:8]});
         read_byte(1'b1, d);
         chk("R6 byte2", {24'd0, d}, {24'd0, rv[7:0]});
         read_byte(1'b0, d);
         chk("R7 fill byte", {24'd0, d}, 32'hFF);
         bus_stop();
      end

      // R8: controller NAK ends transmission
      res = 24'h000000;
      bus_start();
      write_byte({DEV, 1'b1}, ack);
      read_byte(1'b0, d);
      chk("R8 first byte", {24'd0, d}, 32'h00);
      pull_cnt = 0;
      read_byte(1'b0, d);
      chk("R8 released byte", {24'd0, d}, 32'hFF);
      chk("R8 no pull", pull_cnt, 0);
      bus_stop();

      // R9: write, repeated start, read
      res = 24'h3C5A96;
      bus_start();
      busy_low = 0;
      write_byte({DEV, 1'b0}, ack);
      write_byte(8'h5A, ack);
      bus_start();
      write_byte({DEV, 1'b1}, ack);
      chk("R9 read addr ack", {31'd0, ack}, 32'd1);
      read_byte(1'b0, d);
      chk("R9 read byte", {24'd0, d}, 32'h3C);
      chk("R9 busy held", busy_low, 0);
      bus_stop();
      cfg_exp = {8'h5A, cfg_exp[7:0]};
      chk("R9 cfg", {16'd0, cfg}, {16'd0, cfg_exp});

      chk("R10 pull moves with SCL low", r10_viol, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule